// File: doc/BRIEF.md
# Hidden Palette-DAC Command Register Port

This block is the CPU-side port decoder of a palette DAC whose extended command register has no address of its own. The CPU reaches the DAC through byte-wide ports selected by a two-bit address: port 0 is the pixel-mask port, port 1 is the index port, and ports 2 and 3 are unused here. After a run of reads on the pixel-mask port, the block redirects exactly one later mask-port access, read or write, to the hidden command register. That access disarms the path, so the access after it reaches the pixel mask again.

The stored command byte is decoded all the time into a pixel-format code and a multiplexed-pixel flag for the pixel pipeline. The CPU interface is a plain strobe bus. Every access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. Read data is registered and appears one cycle after the read strobe.

Top module: `dac_cmd_port`

## Requirements
- R1: After reset the command register is 0x00, the pixel mask is 0xFF, the index register is 0x00, read data is 0x00, the format code is 0 (palette) and the multiplexed flag is 0.
- R2: A write to port 1 stores the byte into the index register. A read of port 1 returns the index register and clears the unlock counter.
- R3: The unlock counter starts at zero after reset or after a clear. Four consecutive pure reads of port 0 arm the hidden path. Each of those four reads returns the pixel mask.
- R4: While armed, the next port-0 read returns the command register, and the next port-0 write stores into the command register and leaves the pixel mask unchanged.
- R5: The access that reaches the command register disarms the path, so the next port-0 access reaches the pixel mask again.
- R6: Any access to a port other than 0 clears the counter. A port-0 write while not armed also clears the counter, and it updates the pixel mask.
- R7: The format code is decoded from command bits 7:4. The value 0x1 gives code 1 (15-bit colour), 0x3 gives code 2 (16-bit colour), 0xD gives code 3 (true colour), and any other value gives code 0 (palette). Bits 3:0 have no effect.
- R8: The multiplexed flag equals command bit 5 when the format code is 0, and is 0 otherwise.
- R9: When read and write are asserted in the same cycle, the access counts as a write. The write is stored, the read returns the contents from before the write, and the counter does not advance (an armed path is consumed).
- R10: Read data updates on the clock edge that samples a read strobe and holds its value through cycles without a read.
- R11: Reads of ports 2 and 3 return 0x00. Writes to them change none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select (0 mask, 1 index, 2-3 unused) |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| pix_mask_o | output | 8 | Current pixel mask |
| pix_fmt_o | output | 2 | Decoded pixel-format code |
| mux_mode_o | output | 1 | Multiplexed pixel mode flag |

## Verification
Two functions can fall in one cycle: consuming the armed hidden path and a write that overlaps a read. The bench provokes this by arming the path with four mask reads and then asserting both strobes on port 0 together. The returned byte must be the old command value, the new value must land in the command register and not in the mask, and the next mask read must see the unlocked mask. Every command value is also swept through the hidden write path, and each decoded format and multiplexed flag is compared with an arithmetic expectation.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  typedef enum logic [1:0] {
    PF_PALETTE = 2'd0,
    PF_RGB15   = 2'd1,
    PF_RGB16   = 2'd2,
    PF_TRUE    = 2'd3
  } pix_fmt_e;

  localparam logic [1:0] PORT_MASK  = 2'd0;
  localparam logic [1:0] PORT_INDEX = 2'd1;

  localparam logic [3:0] HI_RGB15 = 4'h1;
  localparam logic [3:0] HI_RGB16 = 4'h3;
  localparam logic [3:0] HI_TRUE  = 4'hD;
endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq #(
  parameter int UNLOCK_READS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_rd,
  input  logic mask_wr,
  input  logic other_acc,
  output logic armed
);
  localparam int CW = $clog2(UNLOCK_READS + 1);

  logic [CW-1:0] cnt_q;

  assign armed = (cnt_q == CW'(UNLOCK_READS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (other_acc) begin
      cnt_q <= '0;
    end else if ((mask_rd || mask_wr) && armed) begin
      cnt_q <= '0;
    end else if (mask_wr) begin
      cnt_q <= '0;
    end else if (mask_rd) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic [3:0] cmd_hi,
  output pix_fmt_e   fmt,
  output logic       mux_mode
);
  always_comb begin
    unique case (cmd_hi)
      HI_RGB15: fmt = PF_RGB15;
      HI_RGB16: fmt = PF_RGB16;
      HI_TRUE:  fmt = PF_TRUE;
      default:  fmt = PF_PALETTE;
    endcase
  end

  assign mux_mode = (fmt == PF_PALETTE) && cmd_hi[1];
endmodule

// File: rtl/dac_cmd_port.sv
module dac_cmd_port
  import dac_cmd_pkg::*;
#(
  parameter int          DW           = 8,
  parameter int          UNLOCK_READS = 4,
  parameter logic [7:0]  MASK_RST     = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] pix_mask_o,
  output logic [1:0]    pix_fmt_o,
  output logic          mux_mode_o
);
  localparam int HI_LSB = DW - 4;

  logic [DW-1:0] mask_q, cmd_q, idx_q, dout_q, rd_sel;
  logic          at_mask, at_other, armed;
  pix_fmt_e      fmt;

  assign at_mask  = (addr == PORT_MASK);
  assign at_other = (rd || wr) && !at_mask;

  dac_unlock_seq #(.UNLOCK_READS(UNLOCK_READS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_rd   (at_mask && rd && !wr),
    .mask_wr   (at_mask && wr),
    .other_acc (at_other),
    .armed     (armed)
  );

  dac_cmd_decode u_dec (
    .cmd_hi   (cmd_q[DW-1:HI_LSB]),
    .fmt      (fmt),
    .mux_mode (mux_mode_o)
  );

  always_comb begin
    unique case (addr)
      PORT_MASK:  rd_sel = armed ? cmd_q : mask_q;
      PORT_INDEX: rd_sel = idx_q;
      default:    rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= DW'(MASK_RST);
      cmd_q  <= '0;
      idx_q  <= '0;
      dout_q <= '0;
    end else begin
      if (wr) begin
        if (at_mask) begin
          if (armed) cmd_q  <= din;
          else       mask_q <= din;
        end else if (addr == PORT_INDEX) begin
          idx_q <= din;
        end
      end
      if (rd) dout_q <= rd_sel;
    end
  end

  assign dout       = dout_q;
  assign pix_mask_o = mask_q;
  assign pix_fmt_o  = fmt;
endmodule

// File: rtl/dac_cmd_port_chk.sv
module dac_cmd_port_chk
  import dac_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       rd,
  input logic       wr,
  input logic       armed,
  input logic [7:0] cmd_q,
  input logic [7:0] mask_q,
  input logic [1:0] fmt,
  input logic       mux
);
  p_cmd_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == PORT_MASK && armed) |=> $stable(cmd_q));

  p_mask_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == PORT_MASK && armed) |=> $stable(mask_q));

  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (rd || wr) && addr == PORT_MASK) |=> !armed);

  p_index_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == PORT_INDEX) |=> !armed);

  p_mux_palette_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mux |-> (fmt == PF_PALETTE));
endmodule

bind dac_cmd_port dac_cmd_port_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .rd    (rd),
  .wr    (wr),
  .armed (armed),
  .cmd_q (cmd_q),
  .mask_q(mask_q),
  .fmt   (pix_fmt_o),
  .mux   (mux_mode_o)
);

// File: tb/tb_dac_cmd_port.sv
module tb_dac_cmd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, pix_mask_o;
  logic [1:0] pix_fmt_o;
  logic       mux_mode_o;

  int vecs = 0, errs = 0;
  logic [7:0] m_mask = 8'hFF, m_cmd = 8'h00, m_idx = 8'h00, m_last = 8'h00;
  int m_cnt = 0;

  always #4 clk = ~clk;

  dac_cmd_port dut (.*);

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] p, input bit r, input bit w,
                     input logic [7:0] d, input string tag);
    logic [7:0] exp;
    bit arm;
    arm = (m_cnt == 4);
    exp = (p == 2'd0) ? (arm ? m_cmd : m_mask) : (p == 2'd1) ? m_idx : 8'h00;
    @(negedge clk); addr = p; rd = r; wr = w; din = d;
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    if (r) begin check(dout, exp, tag); m_last = exp; end
    else check(dout, m_last, "R10 hold");
    if (w) begin
      if (p == 2'd0) begin if (arm) m_cmd = d; else m_mask = d; end
      else if (p == 2'd1) m_idx = d;
    end
    if (p != 2'd0 || arm || w) m_cnt = 0;
    else if (r) m_cnt++;
    check(pix_mask_o, m_mask, "R4/R6 mask");
  endtask

  task automatic unlock(input string tag);
    acc(2'd1, 1, 0, 8'h00, "R2 index read");
    for (int k = 0; k < 4; k++) acc(2'd0, 1, 0, 8'h00, tag);
  endtask

  task automatic check_fmt(input logic [7:0] v);
    int hi, ef, em;
    hi = v >> 4;
    ef = (hi == 1) ? 1 : (hi == 3) ? 2 : (hi == 13) ? 3 : 0;
    em = (ef == 0) ? ((v >> 5) & 1) : 0;
    check({6'd0, pix_fmt_o}, 8'(ef), "R7 format");
    check({7'd0, mux_mode_o}, 8'(em), "R8 mux");
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout, 8'h00, "R1 dout");
    check(pix_mask_o, 8'hFF, "R1 mask");
    check({6'd0, pix_fmt_o}, 8'h00, "R1 fmt");
    check({7'd0, mux_mode_o}, 8'h00, "R1 mux");
    acc(2'd1, 1, 0, 8'h00, "R1 index");
    unlock("R3 arm reads");
    acc(2'd0, 1, 0, 8'h00, "R1 cmd reset value");

    // sweep every command value through the hidden write path
    for (int v = 0; v < 256; v++) begin
      unlock("R3 arm reads");
      acc(2'd0, 0, 1, 8'(v), "R4 hidden write");
      check_fmt(8'(v));
      acc(2'd0, 1, 0, 8'h00, "R5 mask after hidden");
      unlock("R3 arm reads");
      acc(2'd0, 1, 0, 8'h00, "R4 hidden read");
    end

    // counter interruptions at every depth
    for (int n = 0; n < 6; n++) begin
      for (int kind = 0; kind < 5; kind++) begin
        acc(2'd1, 1, 0, 8'h00, "R2 index read");
        for (int k = 0; k < n; k++) acc(2'd0, 1, 0, 8'h00, "R3 count");
        case (kind)
          0: acc(2'd1, 0, 1, 8'(n * 7 + 1), "R2 index write");
          1: acc(2'd2, 1, 0, 8'h00, "R11 unused read");
          2: acc(2'd3, 0, 1, 8'hA5, "R11 unused write");
          3: acc(2'd0, 0, 1, 8'(8'h40 + n), "R6 mask write");
          default: acc(2'd1, 1, 0, 8'h00, "R2 index readback");
        endcase
        for (int k = 0; k < 5; k++) acc(2'd0, 1, 0, 8'h00, "R6 recount");
      end
    end

    // simultaneous read and write on the armed path
    unlock("R3 arm reads");
    acc(2'd0, 1, 1, 8'h30, "R9 rd+wr armed");
    check_fmt(8'h30);
    acc(2'd0, 1, 1, 8'h12, "R9 rd+wr unarmed");
    acc(2'd0, 1, 0, 8'h00, "R9 no advance");
    for (int k = 0; k < 3; k++) acc(2'd0, 1, 0, 8'h00, "R9 count");
    acc(2'd0, 1, 0, 8'h00, "R9 hidden after");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule